// File: doc/BRIEF.md
# Multi-Row Write-Coalescing Buffer with Masked Eviction

This block sits between a word-oriented requester and a slow, wear-limited non-volatile memory array. It keeps a few narrow rows of the array in on-chip latches, each row tagged with its array row address. Reads and writes that land in a resident row are handled entirely from the latches. Repeated writes to that row are merged there, so the array is not written each time.

When a request misses, the block picks a slot. An empty slot is used first; otherwise the least recently used row is taken. If the departing row holds modified data, the block sends one masked write command to the array. The mask marks only the sub-units changed since the row was loaded. A row with no changes is dropped without any array write. The block then issues one row-read and installs the new row. Three counters record array reads, array write commands and written sub-units, so wear savings can be measured.

The request address is a word address. The upper bits select the array row and the low `log2(ROW_BYTES/WORD_BYTES)` bits select the word inside it (bits [5:0] at default parameters). The dirty sub-unit size is set by `GRAN_BYTES`: one word (4 bytes, 64 mask bits per row) or one 64-byte line (4 mask bits per row).

Top module: `pcmbuf_top`

## Requirements
- R1: After reset, `req_ready`, `rsp_valid` and `arr_req` are low and all three counters read zero.
- R2: A read that hits a resident row is accepted in the cycle `req_ready` is high. `rsp_valid` is high for exactly the next cycle, with the word in `rsp_rdata`. No array command is issued and `stat_reads` does not change.
- R3: A write hit updates only the bytes whose `req_be` bit is set (bit b covers data bits [8b+7:8b]). In the same cycle it sets the dirty bit of sub-unit `word_offset / (GRAN_BYTES/WORD_BYTES)` for that row.
- R4: On a miss, `req_ready` stays low while the array command runs. The block issues exactly one row-read with `arr_row` equal to the upper address bits. After `arr_done`, the row is resident and the held request is then served.
- R5: Empty slots are filled before any resident row is replaced. Once every slot is in use, the least recently accessed row is the one replaced.
- R6: When the departing row has any dirty bit set, the row-read is preceded by exactly one write command (`arr_write` high). That command carries the row's address in `arr_row` and its dirty bits in `arr_wmask`, with bit u covering row bits [u*GRAN_BYTES*8 +: GRAN_BYTES*8]. Sub-units with a clear bit are left unchanged in the array.
- R7: A departing row with no dirty bits causes no write command.
- R8: `stat_reads` counts completed row-reads. `stat_writes` counts completed write commands. `stat_units` adds the number of set mask bits of each completed write.
- R9: While `arr_req` is high and `arr_done` is low, the command (`arr_write`, `arr_row`, `arr_wmask`) holds steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address: row in upper bits, word offset in low bits |
| req_wdata | input | WORD_BYTES*8 | Write data |
| req_be | input | WORD_BYTES | Byte enables for writes |
| req_ready | output | 1 | Request accepted this cycle (high only on a resident row while idle) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | WORD_BYTES*8 | Read data |
| arr_req | output | 1 | Array command pending |
| arr_write | output | 1 | 1 = masked row write, 0 = row read |
| arr_row | output | ADDR_W-log2(ROW_BYTES/WORD_BYTES) | Array row address |
| arr_wmask | output | ROW_BYTES/GRAN_BYTES | Sub-unit write mask |
| arr_wdata | output | ROW_BYTES*8 | Row data for writes |
| arr_done | input | 1 | One-cycle completion pulse from the array |
| arr_rdata | input | ROW_BYTES*8 | Row data, valid with `arr_done` on a read |
| stat_reads | output | CNT_W | Array row-reads completed |
| stat_writes | output | CNT_W | Array write commands completed |
| stat_units | output | CNT_W | Sub-units written to the array |

## Verification
A read hit's data and `rsp_valid` come from one register stage, so they are due on the first rising edge after the edge that accepted the request. The bench drives at a falling edge, waits for that rising edge, and reads them at the following falling edge. On a miss, `req_ready` is combinational on the resident tags and stays low until the edge that completes the fill, so the bench polls it at each falling edge and checks that it never rises while `arr_req` is high. The counters and the resident row change on the edge that samples `arr_done`. The array model raises `arr_done` several cycles after each command and holds it for one cycle. The bench therefore compares the counters and the model's captured commands only once the request has been served.

// File: rtl/pcmbuf_pkg.sv
package pcmbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2
    } fsm_e;

endpackage

// File: rtl/pcmbuf_lookup.sv
module pcmbuf_lookup #(
    parameter int ROWS  = 4,
    parameter int TAG_W = 4,
    parameter int IDX_W = $clog2(ROWS)
) (
    input  logic [ROWS-1:0]            row_valid,
    input  logic [ROWS-1:0][TAG_W-1:0] row_tag,
    input  logic [TAG_W-1:0]           probe_tag,
    input  logic [IDX_W-1:0]           lru_idx,
    output logic                       hit,
    output logic [IDX_W-1:0]           hit_idx,
    output logic [IDX_W-1:0]           victim_idx
);

    logic [ROWS-1:0] match;

    for (genvar i = 0; i < ROWS; i++) begin : g_match
        assign match[i] = row_valid[i] && (row_tag[i] == probe_tag);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    // An empty slot (lowest index) is preferred over the LRU row
    always_comb begin
        victim_idx = lru_idx;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (!row_valid[i]) victim_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/pcmbuf_lru.sv
module pcmbuf_lru #(
    parameter int ROWS  = 4,
    parameter int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] lru_idx
);

    typedef struct packed {
        logic [ROWS-1:0][IDX_W-1:0] age;
    } lru_t;

    lru_t lru_d, lru_q;
    logic [ROWS-1:0] oldest;

    for (genvar i = 0; i < ROWS; i++) begin : g_old
        assign oldest[i] = (lru_q.age[i] == IDX_W'(ROWS - 1));
    end

    always_comb begin
        lru_d = lru_q;
        if (touch) begin
            for (int i = 0; i < ROWS; i++) begin
                if (lru_q.age[i] < lru_q.age[touch_idx]) lru_d.age[i] = lru_q.age[i] + 1'b1;
            end
            lru_d.age[touch_idx] = '0;
        end
        lru_idx = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (oldest[i]) lru_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) lru_q.age[i] <= IDX_W'(i);
        end else begin
            lru_q <= lru_d;
        end
    end

    // R5: ages stay a permutation, so exactly one row is the oldest
    p_one_oldest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1);

endmodule

// File: rtl/pcmbuf_stats.sv
module pcmbuf_stats #(
    parameter int UNITS = 64,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_done,
    input  logic             wr_done,
    input  logic [UNITS-1:0] wr_mask,
    output logic [CNT_W-1:0] reads,
    output logic [CNT_W-1:0] writes,
    output logic [CNT_W-1:0] units
);

    typedef struct packed {
        logic [CNT_W-1:0] rd;
        logic [CNT_W-1:0] wr;
        logic [CNT_W-1:0] un;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (rd_done) cnt_d.rd = cnt_q.rd + 1'b1;
        if (wr_done) begin
            cnt_d.wr = cnt_q.wr + 1'b1;
            cnt_d.un = cnt_q.un + CNT_W'($countones(wr_mask));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign reads  = cnt_q.rd;
    assign writes = cnt_q.wr;
    assign units  = cnt_q.un;

    // R8: every write command carries at least one unit
    p_units_cover_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        units >= writes);

    // R8: write count moves only on a completed write
    p_writes_only_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_done |=> $stable(writes));

endmodule

// File: rtl/pcmbuf_top.sv
module pcmbuf_top
    import pcmbuf_pkg::*;
#(
    parameter int ROWS       = 4,
    parameter int ROW_BYTES  = 256,
    parameter int WORD_BYTES = 4,
    parameter int GRAN_BYTES = 4,
    parameter int ADDR_W     = 10,
    parameter int CNT_W      = 16,
    localparam int WORD_BITS = WORD_BYTES * 8,
    localparam int ROW_BITS  = ROW_BYTES * 8,
    localparam int WPR       = ROW_BYTES / WORD_BYTES,
    localparam int WOFF_W    = $clog2(WPR),
    localparam int TAG_W     = ADDR_W - WOFF_W,
    localparam int UNITS     = ROW_BYTES / GRAN_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [WORD_BITS-1:0]  req_wdata,
    input  logic [WORD_BYTES-1:0] req_be,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic [WORD_BITS-1:0]  rsp_rdata,
    output logic                  arr_req,
    output logic                  arr_write,
    output logic [TAG_W-1:0]      arr_row,
    output logic [UNITS-1:0]      arr_wmask,
    output logic [ROW_BITS-1:0]   arr_wdata,
    input  logic                  arr_done,
    input  logic [ROW_BITS-1:0]   arr_rdata,
    output logic [CNT_W-1:0]      stat_reads,
    output logic [CNT_W-1:0]      stat_writes,
    output logic [CNT_W-1:0]      stat_units
);

    localparam int IDX_W  = $clog2(ROWS);
    localparam int WPU    = GRAN_BYTES / WORD_BYTES;
    localparam int WPU_W  = $clog2(WPU);
    localparam int UNIT_W = $clog2(UNITS);

    typedef struct packed {
        fsm_e                              fsm;
        logic [IDX_W-1:0]                  slot;
        logic [TAG_W-1:0]                  fill_tag;
        logic [ROWS-1:0]                   valid;
        logic [ROWS-1:0][TAG_W-1:0]        tag;
        logic [ROWS-1:0][UNITS-1:0]        dirty;
        logic [ROWS-1:0][ROW_BITS-1:0]     data;
        logic                              rsp_v;
        logic [WORD_BITS-1:0]              rsp_d;
    } buf_t;

    buf_t b_d, b_q;

    logic [TAG_W-1:0]  req_tag;
    logic [WOFF_W-1:0] req_woff;
    logic [UNIT_W-1:0] unit_idx;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  victim_idx;
    logic [IDX_W-1:0]  lru_idx;
    logic              touch;
    logic [IDX_W-1:0]  touch_idx;
    logic              fill_done;
    logic              evict_done;

    assign req_tag  = req_addr[ADDR_W-1:WOFF_W];
    assign req_woff = req_addr[WOFF_W-1:0];
    assign unit_idx = UNIT_W'(req_woff >> WPU_W);

    pcmbuf_lookup #(.ROWS(ROWS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lookup (
        .row_valid  (b_q.valid),
        .row_tag    (b_q.tag),
        .probe_tag  (req_tag),
        .lru_idx    (lru_idx),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .victim_idx (victim_idx)
    );

    pcmbuf_lru #(.ROWS(ROWS), .IDX_W(IDX_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .lru_idx   (lru_idx)
    );

    assign fill_done  = (b_q.fsm == ST_FILL)  && arr_done;
    assign evict_done = (b_q.fsm == ST_EVICT) && arr_done;

    pcmbuf_stats #(.UNITS(UNITS), .CNT_W(CNT_W)) u_stats (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_done (fill_done),
        .wr_done (evict_done),
        .wr_mask (b_q.dirty[b_q.slot]),
        .reads   (stat_reads),
        .writes  (stat_writes),
        .units   (stat_units)
    );

    always_comb begin
        b_d       = b_q;
        b_d.rsp_v = 1'b0;
        touch     = 1'b0;
        touch_idx = hit_idx;
        unique case (b_q.fsm)
            ST_IDLE: begin
                if (req_valid) begin
                    if (hit) begin
                        touch = 1'b1;
                        if (req_write) begin
                            for (int b = 0; b < WORD_BYTES; b++) begin
                                if (req_be[b])
                                    b_d.data[hit_idx][int'(req_woff) * WORD_BITS + b * 8 +: 8] =
                                        req_wdata[b * 8 +: 8];
                            end
                            b_d.dirty[hit_idx][unit_idx] = 1'b1;
                        end else begin
                            b_d.rsp_v = 1'b1;
                            b_d.rsp_d = b_q.data[hit_idx][int'(req_woff) * WORD_BITS +: WORD_BITS];
                        end
                    end else begin
                        b_d.slot              = victim_idx;
                        b_d.fill_tag          = req_tag;
                        b_d.valid[victim_idx] = 1'b0;
                        if (b_q.valid[victim_idx] && (|b_q.dirty[victim_idx]))
                            b_d.fsm = ST_EVICT;
                        else
                            b_d.fsm = ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                if (arr_done) begin
                    b_d.dirty[b_q.slot] = '0;
                    b_d.fsm             = ST_FILL;
                end
            end
            ST_FILL: begin
                if (arr_done) begin
                    b_d.data[b_q.slot]  = arr_rdata;
                    b_d.tag[b_q.slot]   = b_q.fill_tag;
                    b_d.valid[b_q.slot] = 1'b1;
                    b_d.dirty[b_q.slot] = '0;
                    b_d.fsm             = ST_IDLE;
                    touch               = 1'b1;
                    touch_idx           = b_q.slot;
                end
            end
            default: b_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign req_ready = (b_q.fsm == ST_IDLE) && hit;
    assign rsp_valid = b_q.rsp_v;
    assign rsp_rdata = b_q.rsp_d;
    assign arr_req   = (b_q.fsm != ST_IDLE);
    assign arr_write = (b_q.fsm == ST_EVICT);
    assign arr_row   = (b_q.fsm == ST_EVICT) ? b_q.tag[b_q.slot] : b_q.fill_tag;
    assign arr_wmask = (b_q.fsm == ST_EVICT) ? b_q.dirty[b_q.slot] : '0;
    assign arr_wdata = b_q.data[b_q.slot];

    // R2: an accepted read answers on the next cycle without touching the array
    p_read_hit_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_write |=> rsp_valid && !arr_req);

    // R2: no response without an accepted read
    p_no_stray_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && !req_write));

    // R3: the written sub-unit is marked dirty right after the write
    p_dirty_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_write |=> b_q.dirty[$past(hit_idx)][$past(unit_idx)]);

    // R4: the front port is closed while an array command runs
    p_no_ready_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> !req_ready);

    // R6: a write command never carries an empty mask
    p_nonzero_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && arr_write |-> arr_wmask != '0);

    // R9: a pending command is held until completion
    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && !arr_done |=> arr_req && $stable(arr_write) && $stable(arr_row)
                                 && $stable(arr_wmask));

endmodule

// File: tb/sim_pcmbuf_top.sv
module sim_pcmbuf_top;

    localparam int ROW_BITS = 2048;
    localparam int NROWS_A  = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_write = 1'b0;
    logic [9:0]          req_addr = '0;
    logic [31:0]         req_wdata = '0;
    logic [3:0]          req_be = '0;
    logic                req_ready;
    logic                rsp_valid;
    logic [31:0]         rsp_rdata;
    logic                arr_req;
    logic                arr_write;
    logic [3:0]          arr_row;
    logic [63:0]         arr_wmask;
    logic [ROW_BITS-1:0] arr_wdata;
    logic                arr_done = 1'b0;
    logic [ROW_BITS-1:0] arr_rdata = '0;
    logic [15:0]         stat_reads;
    logic [15:0]         stat_writes;
    logic [15:0]         stat_units;

    pcmbuf_top u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .arr_req(arr_req), .arr_write(arr_write), .arr_row(arr_row),
        .arr_wmask(arr_wmask), .arr_wdata(arr_wdata),
        .arr_done(arr_done), .arr_rdata(arr_rdata),
        .stat_reads(stat_reads), .stat_writes(stat_writes), .stat_units(stat_units)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [ROW_BITS-1:0] amem [NROWS_A];
    int          mdl_rd = 0;
    int          mdl_wr = 0;
    logic [3:0]  last_wr_row = '0;
    logic [63:0] last_wr_mask = '0;
    bit          busy_ready_seen = 1'b0;

    function automatic logic [31:0] init_word(int r, int w);
        return 32'hA500_0000 | (32'(r) << 16) | 32'(w);
    endfunction

    function automatic logic [9:0] adr(int r, int w);
        return 10'(r * 64 + w);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Array model: answers each command a few cycles later with a one-cycle done
    initial begin
        for (int r = 0; r < NROWS_A; r++)
            for (int w = 0; w < 64; w++) amem[r][w * 32 +: 32] = init_word(r, w);
        forever begin
            @(negedge clk);
            if (arr_req && !arr_done) begin
                repeat (3) @(negedge clk);
                if (arr_write) begin
                    for (int u = 0; u < 64; u++)
                        if (arr_wmask[u]) amem[arr_row][u * 32 +: 32] = arr_wdata[u * 32 +: 32];
                    mdl_wr++;
                    last_wr_row  = arr_row;
                    last_wr_mask = arr_wmask;
                end else begin
                    arr_rdata = amem[arr_row];
                    mdl_rd++;
                end
                arr_done = 1'b1;
                @(negedge clk);
                arr_done = 1'b0;
            end
        end
    end

    logic [31:0] rd_val;
    bit          rd_vld;

    task automatic access(input bit wr, input logic [9:0] a, input logic [31:0] d,
                          input logic [3:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
            if (arr_req && req_ready) busy_ready_seen = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rd_val = rsp_rdata;
        rd_vld = rsp_valid;
    endtask

    typedef struct packed {
        logic        wr;
        logic [9:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 10'd67,  32'h0,         32'hA501_0003},
        '{1'b1, 10'd67,  32'h1111_0001, 32'h0},
        '{1'b0, 10'd67,  32'h0,         32'h1111_0001},
        '{1'b1, 10'd128, 32'h2222_0000, 32'h0},
        '{1'b0, 10'd128, 32'h0,         32'h2222_0000},
        '{1'b0, 10'd255, 32'h0,         32'hA503_003F},
        '{1'b0, 10'd266, 32'h0,         32'hA504_000A},
        '{1'b1, 10'd84,  32'h1111_2020, 32'h0}
    };

    initial begin
        logic [15:0] rd_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(!req_ready && !rsp_valid && !arr_req, "R1 idle outputs",
            {req_ready, rsp_valid, arr_req}, 0);
        chk(stat_reads == 0 && stat_writes == 0 && stat_units == 0, "R1 counters",
            {stat_reads, stat_writes, stat_units}, 0);

        // Table walk: fills four slots, hits, merged writes
        for (int i = 0; i < 8; i++) begin
            access(VEC[i].wr, VEC[i].addr, VEC[i].data, 4'hF);
            if (!VEC[i].wr)
                chk(rd_vld && rd_val == VEC[i].exp, "R2/R4 table read data",
                    {31'(0), rd_vld, rd_val}, {32'h1, VEC[i].exp});
        end
        // R5: four rows fit in empty slots, no write yet
        chk(stat_reads == 4 && stat_writes == 0, "R5 empty slots first",
            {stat_reads, stat_writes}, {16'd4, 16'd0});
        chk(mdl_rd == 4, "R4 one row-read per miss", 64'(mdl_rd), 4);

        // R6/R5: row5 miss replaces LRU row2, dirty word 0 only
        access(1'b0, adr(5, 0), 32'h0, 4'hF);
        chk(rd_val == init_word(5, 0), "R4 miss data", rd_val, init_word(5, 0));
        chk(last_wr_row == 4'd2 && mdl_wr == 1, "R5 LRU victim row2",
            {last_wr_row, 32'(mdl_wr)}, {4'd2, 32'd1});
        chk(last_wr_mask == 64'h1, "R6 mask word0", last_wr_mask, 64'h1);
        chk(stat_writes == 1 && stat_units == 1, "R8 after first eviction",
            {stat_writes, stat_units}, {16'd1, 16'd1});

        // R2: row1 still resident, hit with no array read
        rd_before = stat_reads;
        access(1'b0, adr(1, 3), 32'h0, 4'hF);
        chk(rd_vld && rd_val == 32'h1111_0001, "R2 hit data", rd_val, 32'h1111_0001);
        chk(stat_reads == rd_before && mdl_rd == 5, "R2 no array read on hit",
            stat_reads, rd_before);

        // R7: row6 replaces clean row3, no write command
        access(1'b0, adr(6, 0), 32'h0, 4'hF);
        chk(mdl_wr == 1 && stat_writes == 1, "R7 clean drop", 64'(mdl_wr), 1);

        // Row2 returns from the array with its written word
        access(1'b0, adr(2, 0), 32'h0, 4'hF);
        chk(rd_val == 32'h2222_0000, "R6 written word persisted", rd_val, 32'h2222_0000);
        chk(mdl_wr == 1, "R7 clean row4 dropped", 64'(mdl_wr), 1);

        // R3 byte enable on a fresh row (row7 replaces clean row5)
        access(1'b0, adr(7, 1), 32'h0, 4'hF);
        access(1'b1, adr(7, 1), 32'h0000_BB00, 4'b0010);
        access(1'b0, adr(7, 1), 32'h0, 4'hF);
        chk(rd_val == 32'hA507_BB01, "R3 byte enable", rd_val, 32'hA507_BB01);

        // R6 partial write: row1 dirty in words 3 and 20; word 4 must stay as poked
        amem[1][4 * 32 +: 32] = 32'hDEAD_BEEF;
        access(1'b0, adr(8, 0), 32'h0, 4'hF);
        chk(last_wr_row == 4'd1, "R6 evicted row1", last_wr_row, 1);
        chk(last_wr_mask == 64'h0000_0000_0010_0008, "R6 mask words 3,20",
            last_wr_mask, 64'h0000_0000_0010_0008);
        chk(amem[1][4 * 32 +: 32] == 32'hDEAD_BEEF, "R6 clean unit untouched",
            amem[1][4 * 32 +: 32], 32'hDEAD_BEEF);
        chk(amem[1][3 * 32 +: 32] == 32'h1111_0001 && amem[1][20 * 32 +: 32] == 32'h1111_2020,
            "R6 dirty units written", amem[1][20 * 32 +: 32], 32'h1111_2020);

        // R8 final counters, R4 ready never high with a command pending
        chk(stat_reads == 16'd9 && stat_writes == 16'd2 && stat_units == 16'd3,
            "R8 final counters", {stat_reads, stat_writes, stat_units},
            {16'd9, 16'd2, 16'd3});
        chk(stat_reads == 16'(mdl_rd) && stat_writes == 16'(mdl_wr), "R8 match array",
            {stat_reads, stat_writes}, {16'(mdl_rd), 16'(mdl_wr)});
        chk(!busy_ready_seen, "R4 ready low during fill", 64'(busy_ready_seen), 0);
        chk(!arr_req, "R9 command released", 64'(arr_req), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule